// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides a fast oscillator clock by a modulus that is reloaded at the end of every divided cycle. Over many cycles the mean division ratio equals an integer modulus plus a 24-bit binary fraction. The fraction is resolved to 2^-24 of one modulus step. It sits in the feedback path of a frequency-multiplying loop. The phase comparator, loop filter and oscillator are outside the block.

Two sources can produce the per-cycle modulus offset. In first-order mode a single 24-bit accumulator adds the fraction at each reload, and its carry lengthens that cycle by one clock. This gives a short repeating pattern whose period is set by the fraction. In delta-sigma mode three cascaded accumulators have their carries merged through first- and second-difference networks. This spreads the offset over the levels -3 to +4 and pushes the dithering error toward high frequency.

The integer modulus, fraction and mode are plain control pins. They are sampled only at the reload instant, so a change never disturbs a cycle in progress. The offset that applies to the current cycle is brought out for observation. There is no streaming interface, so no back-pressure applies.

Top module: `fracn_fb_divider`

## Requirements
- R1: Synchronous reset clears all modulator state and drives `mod_offset` to 0 and `div_out` to 0. It loads the counter with the clamped integer modulus M, so the first pulse after release arrives M clocks after the last reset edge.
- R2: `div_out` is high for exactly one clock per divided cycle. The number of clocks between consecutive pulses equals the effective modulus of that cycle. `mod_offset` changes only on the clock edge that follows a pulse and holds the offset of the cycle then in progress.
- R3: With `mode_sel` = 0 (first-order), the offset applied at the k-th reload after reset is floor(k·F/2^24) − floor((k−1)·F/2^24), where F is `frac_word`. For example, F = 0x400000 with integer 10 gives periods 10, 10, 10, 11, repeating.
- R4: With `mode_sel` = 1 (delta-sigma), every offset lies in the range -3 to +4.
- R5: In delta-sigma mode, with F constant since reset, the sum of the first n offsets lies between floor(n·F/2^24) − 1 and floor(n·F/2^24) + 2.
- R6: In delta-sigma mode with F = 0x555555, the offset takes at least one value outside {0, 1} within 1024 cycles.
- R7: With F = 0 since reset, every period equals the integer modulus and `mod_offset` stays 0, in both modes.
- R8: The effective modulus is the integer plus the offset, clamped to a minimum of 4.
- R9: `int_mod`, `frac_word` and `mode_sel` are sampled only at the reload. A change made mid-cycle leaves the current period unchanged and takes effect from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| int_mod | input | INT_W (8) | Integer part of the division ratio |
| frac_word | input | FRAC_W (24) | Fractional part, in units of 2^-FRAC_W |
| mode_sel | input | 1 | 0 = first-order accumulator, 1 = third-order delta-sigma |
| div_out | output | 1 | One-clock pulse per divided cycle |
| mod_offset | output | 4 | Signed offset added to the integer for the current cycle |

## Verification
Suppose an accumulator or difference register holds a wrong value. The next pulse spacing then departs from the exact first-order carry pattern, and `mod_offset` disagrees with the measured period, both within one divided cycle of the fault. In delta-sigma mode a corrupted stage shows up as a drift in the running sum of offsets, which exceeds the allowed window after a few hundred cycles. Offsets outside -3 to +4 are visible on the very cycle they occur. A fault in the counter or in the reload sampling shows as a period that differs from the clamped modulus on the same cycle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int OFF_W   = 4;
  localparam int MIN_MOD = 4;

  typedef enum logic {
    MODE_FIRST = 1'b0,
    MODE_MASH  = 1'b1
  } dsm_mode_e;
endpackage

// File: rtl/fracn_accum.sv
// One wrapping accumulator stage: reports the carry and the new sum that the
// next step would store, and commits it on step.
module fracn_accum #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_nxt,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   wide_sum;

  always_comb begin
    wide_sum = {1'b0, acc_q} + {1'b0, addend};
    sum_nxt  = wide_sum[W-1:0];
    carry    = wide_sum[W];
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= sum_nxt;
  end
endmodule

// File: rtl/fracn_mash111.sv
// Three cascaded accumulators with carry recombination. The first stage's
// carry alone is the first-order sequence.
module fracn_mash111
  import fracn_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic [W-1:0]            frac,
  output logic                    carry1,
  output logic signed [OFF_W-1:0] shaped
);
  logic [W-1:0] s1_nxt, s2_nxt, s3_nxt;
  logic         c2, c3;
  logic         c2_d, c3_d, c3_dd;

  fracn_accum #(.W(W)) u_st1 (
    .clk(clk), .rst(rst), .step(step), .addend(frac),
    .sum_nxt(s1_nxt), .carry(carry1)
  );
  fracn_accum #(.W(W)) u_st2 (
    .clk(clk), .rst(rst), .step(step), .addend(s1_nxt),
    .sum_nxt(s2_nxt), .carry(c2)
  );
  fracn_accum #(.W(W)) u_st3 (
    .clk(clk), .rst(rst), .step(step), .addend(s2_nxt),
    .sum_nxt(s3_nxt), .carry(c3)
  );

  // Difference-network history
  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      c2_d  <= c2;
      c3_d  <= c3;
      c3_dd <= c3_d;
    end
  end

  // y = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3
  always_comb begin
    shaped = $signed({{(OFF_W-1){1'b0}}, carry1})
           + $signed({{(OFF_W-1){1'b0}}, c2})
           - $signed({{(OFF_W-1){1'b0}}, c2_d})
           + $signed({{(OFF_W-1){1'b0}}, c3})
           - $signed({{(OFF_W-2){1'b0}}, c3_d, 1'b0})
           + $signed({{(OFF_W-1){1'b0}}, c3_dd});
  end

  logic unused_tail;
  assign unused_tail = ^s3_nxt;
endmodule

// File: rtl/fracn_div_counter.sv
// Down-counter: reloads with modulus-1 at terminal count; reset loads the
// full modulus so the first pulse lands M edges after reset.
module fracn_div_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rst_val,
  input  logic [CNT_W-1:0] load_val,
  output logic             tc
);
  logic [CNT_W-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= rst_val;
    else if (tc) cnt_q <= load_val - CNT_W'(1);
    else         cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
  import fracn_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W-1:0]        int_mod,
  input  logic [FRAC_W-1:0]       frac_word,
  input  logic                    mode_sel,
  output logic                    div_out,
  output logic signed [OFF_W-1:0] mod_offset
);
  localparam int CNT_W = INT_W + 1;
  localparam int SUM_W = INT_W + 2;

  dsm_mode_e               mode_in, mode_q;
  logic                    tc, step, carry1;
  logic signed [OFF_W-1:0] shaped, offset_sel, off_q;
  logic signed [SUM_W-1:0] mod_sum;
  logic [CNT_W-1:0]        mod_eff, mod_rst;

  assign mode_in = dsm_mode_e'(mode_sel);
  assign step    = tc & ~rst;

  fracn_mash111 #(.W(FRAC_W)) u_mod (
    .clk(clk), .rst(rst), .step(step), .frac(frac_word),
    .carry1(carry1), .shaped(shaped)
  );

  always_comb begin
    offset_sel = (mode_in == MODE_MASH) ? shaped
                                        : $signed({{(OFF_W-1){1'b0}}, carry1});
    mod_sum = $signed({2'b00, int_mod})
            + $signed({{(SUM_W-OFF_W){offset_sel[OFF_W-1]}}, offset_sel});
    if (mod_sum < $signed(SUM_W'(MIN_MOD))) mod_eff = CNT_W'(MIN_MOD);
    else                                    mod_eff = mod_sum[CNT_W-1:0];
    if (int_mod < INT_W'(MIN_MOD)) mod_rst = CNT_W'(MIN_MOD);
    else                           mod_rst = {1'b0, int_mod};
  end

  fracn_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rst_val(mod_rst), .load_val(mod_eff), .tc(tc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      mode_q <= mode_in;
    end else if (step) begin
      off_q  <= offset_sel;
      mode_q <= mode_in;
    end
  end

  assign div_out    = tc;
  assign mod_offset = off_q;
endmodule

// File: rtl/fracn_fb_divider_checker.sv
module fracn_fb_divider_checker
  import fracn_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    div_out,
  input logic signed [OFF_W-1:0] mod_offset,
  input logic                    mode_q
);
  logic [3:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (div_out)       gap_q <= '0;
    else if (gap_q != 4'hF) gap_q <= gap_q + 4'd1;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  a_r2_offset_held: assert property (@(posedge clk) disable iff (rst)
    !$past(div_out) |-> $stable(mod_offset));

  a_r8_min_spacing: assert property (@(posedge clk) disable iff (rst)
    div_out |-> (gap_q >= 4'd3));

  a_r4_offset_range: assert property (@(posedge clk) disable iff (rst)
    (mod_offset >= -4'sd3) && (mod_offset <= 4'sd4));

  a_r3_first_order_binary: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 1'b0) |-> (mod_offset == 4'sd0 || mod_offset == 4'sd1));
endmodule

bind fracn_fb_divider fracn_fb_divider_checker u_chk (
  .clk(clk), .rst(rst), .div_out(div_out),
  .mod_offset(mod_offset), .mode_q(mode_q)
);

// File: tb/fracn_fb_divider_test.sv
module fracn_fb_divider_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        int_mod = 8'd10;
  logic [23:0]       frac_word = '0;
  logic              mode_sel = 1'b0;
  logic              div_out;
  logic signed [3:0] mod_offset;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fracn_fb_divider uut (
    .clk(clk), .rst(rst), .int_mod(int_mod), .frac_word(frac_word),
    .mode_sel(mode_sel), .div_out(div_out), .mod_offset(mod_offset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint fo_off(longint k, longint f);
    return ((k * f) >> 24) - (((k - 1) * f) >> 24);
  endfunction

  function automatic int eff_mod(int im, int off);
    return (im + off < 4) ? 4 : im + off;
  endfunction

  task automatic wait_pulse(output int len, output int off);
    len = 0;
    off = 0;
    forever begin
      @(negedge clk);
      len++;
      if (len == 1) off = int'(mod_offset);
      if (div_out) break;
    end
  endtask

  // Reset with given settings, check reset state (R1) and the first period.
  task automatic start(input int im, input int f, input bit m);
    int len, off;
    @(negedge clk);
    rst = 1'b1;
    int_mod = 8'(im);
    frac_word = 24'(f);
    mode_sel = m;
    repeat (3) @(negedge clk);
    chk(div_out == 1'b0, "R1", "div_out in reset", longint'(div_out), 0);
    chk(mod_offset == 0, "R1", "mod_offset in reset", longint'(mod_offset), 0);
    rst = 1'b0;
    wait_pulse(len, off);
    chk(len == eff_mod(im, 0), "R1", "first period after reset", len, eff_mod(im, 0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int len, off, bad;
    longint sum, lo, hi;
    bit multi;
    void'($urandom(32'd20240611));

    // R3: directed 10 + 0.25 pattern
    start(10, 24'h400000, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      wait_pulse(len, off);
      chk(len == ((k % 4 == 0) ? 11 : 10), "R3", "10.25 pattern period", len,
          (k % 4 == 0) ? 11 : 10);
      chk(off == len - 10, "R2", "offset matches period", off, len - 10);
    end

    // R7: zero fraction, both modes
    for (int m = 0; m < 2; m++) begin
      start(7, 0, 1'(m));
      bad = 0;
      for (int k = 0; k < 16; k++) begin
        wait_pulse(len, off);
        if (len != 7 || off != 0) bad++;
      end
      chk(bad == 0, "R7", "zero-fraction cycles off nominal", bad, 0);
    end

    // R3/R2: random first-order runs against the floor formula
    for (int r = 0; r < 5; r++) begin
      int im, f;
      im = int'($urandom_range(24, 4));
      f  = int'($urandom & 32'h00FF_FFFF);
      start(im, f, 1'b0);
      bad = 0;
      for (int k = 1; k <= 256; k++) begin
        wait_pulse(len, off);
        if (off != int'(fo_off(k, f)) || len != eff_mod(im, off)) begin
          if (bad == 0)
            $display("FAIL R3 first-order k=%0d: actual period %0d expected %0d",
                     k, len, eff_mod(im, int'(fo_off(k, f))));
          bad++;
        end
      end
      chk(bad == 0, "R3", "first-order mismatching cycles", bad, 0);
    end

    // R4/R5: delta-sigma run of 4096 cycles, random fraction
    begin
      int im, f;
      im = int'($urandom_range(11, 8));
      f  = int'($urandom & 32'h00FF_FFFF) | 1;
      start(im, f, 1'b1);
      bad = 0;
      sum = 0;
      for (int k = 1; k <= 4096; k++) begin
        wait_pulse(len, off);
        if (off < -3 || off > 4 || len != im + off) bad++;
        sum += off;
      end
      chk(bad == 0, "R4", "offset out of range or period mismatch", bad, 0);
      lo = ((longint'(4096) * f) >> 24) - 1;
      hi = lo + 3;
      chk(sum >= lo && sum <= hi, "R5", "sum of offsets over 4096", sum, lo + 1);
    end

    // R6: multi-level dithering
    start(10, 24'h555555, 1'b1);
    multi = 1'b0;
    for (int k = 0; k < 1024; k++) begin
      wait_pulse(len, off);
      if (off < 0 || off > 1) multi = 1'b1;
    end
    chk(multi, "R6", "offset left {0,1}", longint'(multi), 1);

    // R8: clamp with integer below minimum
    start(2, 0, 1'b0);
    wait_pulse(len, off);
    chk(len == 4, "R8", "clamped period for integer 2", len, 4);
    start(4, 24'h9A0000, 1'b1);
    bad = 0;
    for (int k = 0; k < 512; k++) begin
      wait_pulse(len, off);
      if (len != eff_mod(4, off) || len < 4) bad++;
    end
    chk(bad == 0, "R8", "clamped delta-sigma periods wrong", bad, 0);

    // R9: mid-cycle change does not touch the running period
    start(10, 0, 1'b0);
    len = 0;
    repeat (3) @(negedge clk);
    len = 3;
    int_mod = 8'd20;
    frac_word = 24'h800000;
    mode_sel = 1'b1;
    forever begin
      @(negedge clk);
      len++;
      if (div_out) break;
    end
    chk(len == 10, "R9", "period after mid-cycle change", len, 10);
    wait_pulse(len, off);
    chk(len == 20, "R9", "next period uses new settings", len, 20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule